// File: doc/BRIEF.md
# I2C Master Multi-Message Sequencer

This block turns a short list of message descriptors into one I2C master transaction. Each descriptor carries a 7-bit target address, a direction, a byte count and a continue-without-restart flag. On `start` the descriptors are captured. The sequencer waits for a quiet bus and sends START with the first address byte. It then moves data bytes through a byte-level engine below it. Between messages it inserts a repeated START with a fresh address byte. It places NAK and STOP on the right bytes and finishes with a one-cycle `done` pulse and a status byte.

Outgoing write bytes arrive on a valid/ready stream, and incoming read bytes leave on a second valid/ready stream. A byte moves on a stream only in a cycle where valid and ready are both high. `wr_ready` is raised only in the cycle that the byte goes straight to the engine. `rd_valid` holds the byte steady until `rd_ready` takes it. While a read byte waits, the bus side stalls. Failures are sorted into three classes. A NAK on the very first address byte repeats the whole transaction after a pause. A NAK anywhere later is final. Any other bus error is also final. A cycle watchdog ends a transaction that hangs. The engine contract is simple: one `eng_go` per command and one `eng_done` per command. The only exception is a stop-only command, which the engine must accept at any time.

Top module: `i2c_msg_sequencer`

## Requirements
- R1: Each address byte sent to the engine is the 7-bit target address in bits 7:1, with bit 0 set to 1 for a read and 0 for a write. It goes out with `eng_start`=1 and `eng_op`=0 (write).
- R2: The first address byte of an attempt is issued only after a cycle in which `bus_busy`=0, `scl_in`=1 and `sda_in`=1.
- R3: A write data byte is sent with `eng_stop`=1 only when it is the last byte of the last message. Every other write byte has `eng_stop`=0.
- R4: A read byte (`eng_op`=1) is requested with `eng_nak`=1 when it is the last byte of its message and the next message does not continue without restart. It carries `eng_stop`=1 only when it is the last byte of the last message.
- R5: When a message ends and another follows, the next message opens with a repeated START and its own address byte. If the next message has its no-restart flag set, its data follows directly and keeps the direction of the running segment.
- R6: A NAK on the address of message 0 before any data byte counts as retryable. A NAK at any later point ends the transaction with status 0x82. An engine bus error ends it with status 0x83. Every failure first issues a stop-only command (`eng_op`=2, `eng_stop`=1).
- R7: A retryable failure restarts the transaction from message 0 after at least GAP_CYCLES idle cycles. At most RETRIES restarts are made. When none remain, the status is 0x81.
- R8: When the last message has length zero, its address byte carries `eng_stop`=1. After it completes, one `eng_reset` pulse is issued before `done`.
- R9: An arbitration-lost report from the engine does not change the command sequence or the status. `arb_seen` is 1 at `done` if such a report occurred during the transaction.
- R10: If the transaction is still on the bus after `timeout_cycles` active cycles, the sequencer issues a stop-only command and reports status 0x84. Cycles spent waiting for `rd_ready`, and the retry pause, are not counted. A value of 0 disables the watchdog.
- R11: `done` is high for exactly one cycle per transaction. With it, `status` equals the number of messages on success, or one of the codes 0x81..0x84 on failure.
- R12: `wr_ready` is high only when a write data byte is due. Each handshake sends exactly that `wr_data` value to the engine in the same cycle.
- R13: While `rd_valid` is high and `rd_ready` is low, `rd_valid` and `rd_data` hold. No engine command is issued while `rd_valid` is high.
- R14: Apart from a stop-only command, `eng_go` is never raised while an earlier command is still waiting for `eng_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transaction with the presented descriptors (ignored unless idle) |
| num_msgs | input | CNT_W | Number of messages, 1..MAX_MSGS |
| msg_addr | input | 7*MAX_MSGS | Target addresses, message i at bits 7i+6:7i |
| msg_rd | input | MAX_MSGS | Direction per message, 1 = read |
| msg_nostart | input | MAX_MSGS | Continue without repeated START per message |
| msg_len | input | LEN_W*MAX_MSGS | Byte count per message |
| timeout_cycles | input | TO_W | Watchdog limit in cycles, 0 = off |
| wr_data | input | 8 | Outgoing write byte |
| wr_valid | input | 1 | Write byte available |
| wr_ready | output | 1 | Write byte taken this cycle |
| rd_data | output | 8 | Received byte |
| rd_valid | output | 1 | Received byte available |
| rd_ready | input | 1 | Consumer takes the received byte |
| done | output | 1 | One-cycle end-of-transaction pulse |
| status | output | 8 | Message count or error code, valid with done |
| arb_seen | output | 1 | Arbitration loss was reported during the transaction |
| eng_go | output | 1 | Issue a command to the byte engine |
| eng_op | output | 2 | 0 write byte, 1 read byte, 2 stop only |
| eng_start | output | 1 | Generate (repeated) START before the byte |
| eng_stop | output | 1 | Generate STOP after the byte |
| eng_nak | output | 1 | Answer the read byte with NAK |
| eng_byte | output | 8 | Byte to send |
| eng_reset | output | 1 | Reset pulse to the byte engine |
| eng_done | input | 1 | Command finished |
| eng_nak_rcvd | input | 1 | Target did not acknowledge the sent byte |
| eng_bus_err | input | 1 | Bus error during the command |
| eng_arb_lost | input | 1 | Arbitration loss reported |
| eng_rx_byte | input | 8 | Byte received by a read command |
| bus_busy | input | 1 | Bus is owned by some master |
| scl_in | input | 1 | Sampled SCL level |
| sda_in | input | 1 | Sampled SDA level |

## Verification
The assertions take for granted that the byte engine answers each command with exactly one `eng_done`. The one exception is a hung command that is overtaken by a stop-only command. They also assume that `num_msgs` lies between 1 and MAX_MSGS at `start`, and that `timeout_cycles` does not change during a transaction. The bench engine model always answers three cycles after a command unless a scenario marks that command as hung. Each scenario sets its descriptor count inside the legal range and leaves the watchdog limit fixed while the transaction runs.

// File: rtl/i2cseq_pkg.sv
package i2cseq_pkg;

  typedef enum logic [1:0] {
    OP_WR   = 2'd0,
    OP_RD   = 2'd1,
    OP_STOP = 2'd2
  } eng_op_e;

  typedef enum logic [3:0] {
    S_IDLE, S_WAIT_BUS, S_ADDR, S_ADDR_W, S_DATA, S_DATA_W, S_RD_OUT,
    S_NEXT, S_SEG, S_RESET, S_FINISH, S_ABORT, S_ABORT_W, S_GAP
  } seq_state_e;

  localparam logic [7:0] ST_OK        = 8'h00;
  localparam logic [7:0] ST_RETRY     = 8'h81;
  localparam logic [7:0] ST_NAK       = 8'h82;
  localparam logic [7:0] ST_BUS_ERR   = 8'h83;
  localparam logic [7:0] ST_TIMEOUT   = 8'h84;

endpackage

// File: rtl/seq_msg_table.sv
module seq_msg_table #(
  parameter int MAX_MSGS = 4,
  parameter int LEN_W    = 8,
  parameter int CNT_W    = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load,
  input  logic [CNT_W-1:0]          num_in,
  input  logic [7*MAX_MSGS-1:0]     addr_in,
  input  logic [MAX_MSGS-1:0]       rd_in,
  input  logic [MAX_MSGS-1:0]       nostart_in,
  input  logic [LEN_W*MAX_MSGS-1:0] len_in,
  input  logic [CNT_W-1:0]          idx,
  output logic [CNT_W-1:0]          num,
  output logic [6:0]                cur_addr,
  output logic                      cur_rd,
  output logic [LEN_W-1:0]          cur_len,
  output logic                      cur_nostart,
  output logic                      next_nostart,
  output logic                      is_last
);

  logic [6:0]       t_addr    [MAX_MSGS];
  logic             t_rd      [MAX_MSGS];
  logic             t_nostart [MAX_MSGS];
  logic [LEN_W-1:0] t_len     [MAX_MSGS];

  always_ff @(posedge clk) begin
    if (!rst_n) num <= '0;
    else if (load) num <= num_in;
  end

  for (genvar g = 0; g < MAX_MSGS; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        t_addr[g]    <= '0;
        t_rd[g]      <= 1'b0;
        t_nostart[g] <= 1'b0;
        t_len[g]     <= '0;
      end else if (load) begin
        t_addr[g]    <= addr_in[7*g +: 7];
        t_rd[g]      <= rd_in[g];
        t_nostart[g] <= nostart_in[g];
        t_len[g]     <= len_in[LEN_W*g +: LEN_W];
      end
    end
  end

  always_comb begin
    cur_addr     = '0;
    cur_rd       = 1'b0;
    cur_len      = '0;
    cur_nostart  = 1'b0;
    next_nostart = 1'b0;
    for (int i = 0; i < MAX_MSGS; i++) begin
      if (idx == CNT_W'(i)) begin
        cur_addr    = t_addr[i];
        cur_rd      = t_rd[i];
        cur_len     = t_len[i];
        cur_nostart = t_nostart[i];
      end
      if (idx + CNT_W'(1) == CNT_W'(i)) next_nostart = t_nostart[i];
    end
  end

  assign is_last = (idx + CNT_W'(1) >= num);

  // R11: the message count presented at load lies inside the table
  always @(posedge clk) begin
    if (rst_n && load) begin
      assert_num_range_R11: assert (num_in != '0 && num_in <= CNT_W'(MAX_MSGS))
        else $error("num_msgs out of range");
    end
  end

endmodule

// File: rtl/seq_watchdog.sv
module seq_watchdog #(
  parameter int TO_W = 20
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear,
  input  logic            enable,
  input  logic [TO_W-1:0] limit,
  output logic            expired
);

  logic [TO_W-1:0] count;

  assign expired = (limit != '0) && (count >= limit);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) count <= '0;
    else if (enable && !expired) count <= count + TO_W'(1);
  end

  // R10: once the limit is reached the counter stops moving until cleared
  assert_wd_saturate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && !clear) |=> $stable(count));

endmodule

// File: rtl/seq_retry_gap.sv
module seq_retry_gap #(
  parameter int RETRIES    = 5,
  parameter int GAP_CYCLES = 25000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic begin_gap,
  output logic can_retry,
  output logic gap_done
);

  localparam int ATT_W = $clog2(RETRIES + 2);
  localparam int GAP_W = $clog2(GAP_CYCLES + 1);

  logic [ATT_W-1:0] attempts;
  logic [GAP_W-1:0] gap_cnt;
  logic             gap_run;

  assign can_retry = (attempts < ATT_W'(RETRIES));
  assign gap_done  = gap_run && (gap_cnt == GAP_W'(GAP_CYCLES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || clear) attempts <= '0;
    else if (begin_gap) attempts <= attempts + ATT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap_run <= 1'b0;
      gap_cnt <= '0;
    end else if (begin_gap) begin
      gap_run <= 1'b1;
      gap_cnt <= '0;
    end else if (gap_done) begin
      gap_run <= 1'b0;
    end else if (gap_run) begin
      gap_cnt <= gap_cnt + GAP_W'(1);
    end
  end

  // R7: the number of restarts never exceeds the allowance
  assert_attempt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    attempts <= ATT_W'(RETRIES));

endmodule

// File: rtl/i2c_msg_sequencer.sv
module i2c_msg_sequencer
  import i2cseq_pkg::*;
#(
  parameter int MAX_MSGS   = 4,
  parameter int LEN_W      = 8,
  parameter int TO_W       = 20,
  parameter int RETRIES    = 5,
  parameter int GAP_CYCLES = 25000,
  localparam int CNT_W     = $clog2(MAX_MSGS + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [CNT_W-1:0]          num_msgs,
  input  logic [7*MAX_MSGS-1:0]     msg_addr,
  input  logic [MAX_MSGS-1:0]       msg_rd,
  input  logic [MAX_MSGS-1:0]       msg_nostart,
  input  logic [LEN_W*MAX_MSGS-1:0] msg_len,
  input  logic [TO_W-1:0]           timeout_cycles,
  input  logic [7:0]                wr_data,
  input  logic                      wr_valid,
  output logic                      wr_ready,
  output logic [7:0]                rd_data,
  output logic                      rd_valid,
  input  logic                      rd_ready,
  output logic                      done,
  output logic [7:0]                status,
  output logic                      arb_seen,
  output logic                      eng_go,
  output logic [1:0]                eng_op,
  output logic                      eng_start,
  output logic                      eng_stop,
  output logic                      eng_nak,
  output logic [7:0]                eng_byte,
  output logic                      eng_reset,
  input  logic                      eng_done,
  input  logic                      eng_nak_rcvd,
  input  logic                      eng_bus_err,
  input  logic                      eng_arb_lost,
  input  logic [7:0]                eng_rx_byte,
  input  logic                      bus_busy,
  input  logic                      scl_in,
  input  logic                      sda_in
);

  seq_state_e       st;
  logic [CNT_W-1:0] idx;
  logic [LEN_W-1:0] ptr;
  logic             seg_rd;
  logic             data_seen;
  logic [7:0]       err;
  logic [7:0]       rx_hold;
  logic             cmd_pending;

  logic [CNT_W-1:0] num;
  logic [6:0]       m_addr;
  logic             m_rd;
  logic [LEN_W-1:0] m_len;
  logic             m_nostart;
  logic             nx_nostart;
  logic             is_last;

  logic wd_clear, wd_en, wd_expired, timeout_hit;
  logic rt_clear, begin_gap, can_retry, gap_done;
  logic bus_ok, last_byte, accept;

  assign accept = (st == S_IDLE) && start;
  assign bus_ok = !bus_busy && scl_in && sda_in;
  assign last_byte = (ptr == m_len - LEN_W'(1));

  seq_msg_table #(.MAX_MSGS(MAX_MSGS), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_table (
    .clk(clk), .rst_n(rst_n), .load(accept), .num_in(num_msgs),
    .addr_in(msg_addr), .rd_in(msg_rd), .nostart_in(msg_nostart), .len_in(msg_len),
    .idx(idx), .num(num), .cur_addr(m_addr), .cur_rd(m_rd), .cur_len(m_len),
    .cur_nostart(m_nostart), .next_nostart(nx_nostart), .is_last(is_last)
  );

  assign wd_clear = (st == S_IDLE) || (st == S_GAP);
  assign wd_en = (st inside {S_WAIT_BUS, S_ADDR, S_ADDR_W, S_DATA, S_DATA_W, S_NEXT, S_SEG});
  assign timeout_hit = wd_en && wd_expired;

  seq_watchdog #(.TO_W(TO_W)) u_wd (
    .clk(clk), .rst_n(rst_n), .clear(wd_clear), .enable(wd_en),
    .limit(timeout_cycles), .expired(wd_expired)
  );

  assign rt_clear  = accept;
  assign begin_gap = (st == S_ABORT_W) && eng_done && (err == ST_RETRY) && can_retry;

  seq_retry_gap #(.RETRIES(RETRIES), .GAP_CYCLES(GAP_CYCLES)) u_retry (
    .clk(clk), .rst_n(rst_n), .clear(rt_clear), .begin_gap(begin_gap),
    .can_retry(can_retry), .gap_done(gap_done)
  );

  // Command and stream outputs
  always_comb begin
    eng_go    = 1'b0;
    eng_op    = OP_WR;
    eng_start = 1'b0;
    eng_stop  = 1'b0;
    eng_nak   = 1'b0;
    eng_byte  = 8'h00;
    eng_reset = 1'b0;
    wr_ready  = 1'b0;
    rd_valid  = 1'b0;
    done      = 1'b0;
    case (st)
      S_ADDR: if (!timeout_hit) begin
        eng_go    = 1'b1;
        eng_start = 1'b1;
        eng_byte  = {m_addr, m_rd};
        eng_stop  = (m_len == '0) && is_last;
      end
      S_DATA: if (!timeout_hit) begin
        if (seg_rd) begin
          eng_go   = 1'b1;
          eng_op   = OP_RD;
          eng_nak  = last_byte && (is_last || !nx_nostart);
          eng_stop = last_byte && is_last;
        end else begin
          wr_ready = 1'b1;
          if (wr_valid) begin
            eng_go   = 1'b1;
            eng_byte = wr_data;
            eng_stop = last_byte && is_last;
          end
        end
      end
      S_RD_OUT: rd_valid = 1'b1;
      S_ABORT: begin
        eng_go   = 1'b1;
        eng_op   = OP_STOP;
        eng_stop = 1'b1;
      end
      S_RESET:  eng_reset = 1'b1;
      S_FINISH: done = 1'b1;
      default: ;
    endcase
  end

  assign rd_data = rx_hold;
  assign status  = done ? ((err == ST_OK) ? 8'(num) : err) : 8'h00;

  // Sequencing
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      idx       <= '0;
      ptr       <= '0;
      seg_rd    <= 1'b0;
      data_seen <= 1'b0;
      err       <= ST_OK;
      rx_hold   <= 8'h00;
    end else if (timeout_hit) begin
      err <= ST_TIMEOUT;
      st  <= S_ABORT;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          idx       <= '0;
          ptr       <= '0;
          data_seen <= 1'b0;
          err       <= ST_OK;
          st        <= S_WAIT_BUS;
        end
        S_WAIT_BUS: if (bus_ok) st <= S_ADDR;
        S_ADDR: st <= S_ADDR_W;
        S_ADDR_W: if (eng_done) begin
          if (eng_nak_rcvd) begin
            err <= (idx == '0 && !data_seen) ? ST_RETRY : ST_NAK;
            st  <= S_ABORT;
          end else if (eng_bus_err) begin
            err <= ST_BUS_ERR;
            st  <= S_ABORT;
          end else begin
            seg_rd <= m_rd;
            st     <= (m_len == '0) ? S_NEXT : S_DATA;
          end
        end
        S_DATA: if (seg_rd || wr_valid) st <= S_DATA_W;
        S_DATA_W: if (eng_done) begin
          if (!seg_rd && eng_nak_rcvd) begin
            err <= ST_NAK;
            st  <= S_ABORT;
          end else if (eng_bus_err) begin
            err <= ST_BUS_ERR;
            st  <= S_ABORT;
          end else begin
            data_seen <= 1'b1;
            ptr       <= ptr + LEN_W'(1);
            if (seg_rd) begin
              rx_hold <= eng_rx_byte;
              st      <= S_RD_OUT;
            end else begin
              st <= last_byte ? S_NEXT : S_DATA;
            end
          end
        end
        S_RD_OUT: if (rd_ready) st <= (ptr == m_len) ? S_NEXT : S_DATA;
        S_NEXT: begin
          if (is_last) begin
            st <= (m_len == '0) ? S_RESET : S_FINISH;
          end else begin
            idx <= idx + CNT_W'(1);
            ptr <= '0;
            st  <= S_SEG;
          end
        end
        S_SEG: begin
          if (m_nostart) st <= (m_len == '0) ? S_NEXT : S_DATA;
          else           st <= S_ADDR;
        end
        S_RESET:  st <= S_FINISH;
        S_FINISH: st <= S_IDLE;
        S_ABORT:  st <= S_ABORT_W;
        S_ABORT_W: if (eng_done) st <= begin_gap ? S_GAP : S_FINISH;
        S_GAP: if (gap_done) begin
          idx       <= '0;
          ptr       <= '0;
          data_seen <= 1'b0;
          err       <= ST_OK;
          st        <= S_WAIT_BUS;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || accept) arb_seen <= 1'b0;
    else if (eng_arb_lost) arb_seen <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cmd_pending <= 1'b0;
    else if (eng_go) cmd_pending <= 1'b1;
    else if (eng_done) cmd_pending <= 1'b0;
  end

  // R11: done is a single-cycle pulse
  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R13: a waiting read byte holds until taken
  assert_rd_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

  // R13: the bus side stalls while a read byte waits
  assert_rd_stall_R13: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !eng_go);

  // R14: one outstanding byte command at a time
  assert_one_cmd_R14: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_go && eng_op != OP_STOP) |-> !cmd_pending);

  // R12: a write handshake forwards that very byte
  assert_wr_forward_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |-> (eng_go && eng_op == OP_WR && eng_byte == wr_data));

  // R2: the opening address only after an idle, released bus
  assert_idle_bus_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_go && eng_start && idx == '0 && !data_seen) |-> $past(bus_ok));

  // R1: address bit 0 matches the message direction
  assert_addr_dir_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_go && eng_start) |-> (eng_byte[0] == m_rd && eng_op == OP_WR));

endmodule

// File: tb/tb_i2c_msg_sequencer.sv
module tb_i2c_msg_sequencer;

  localparam int MAXM  = 4;
  localparam int LENW  = 8;
  localparam int TOW   = 20;
  localparam int RET   = 5;
  localparam int GAP   = 40;
  localparam int CNTW  = $clog2(MAXM + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic             start = 1'b0;
  logic [CNTW-1:0]  num_msgs = '0;
  logic [7*MAXM-1:0] msg_addr = '0;
  logic [MAXM-1:0]  msg_rd = '0, msg_nostart = '0;
  logic [LENW*MAXM-1:0] msg_len = '0;
  logic [TOW-1:0]   timeout_cycles = TOW'(1000);
  logic [7:0] wr_data, rd_data, status, eng_byte, eng_rx_byte;
  logic wr_valid, wr_ready, rd_valid, rd_ready, done, arb_seen;
  logic eng_go, eng_start, eng_stop, eng_nak, eng_reset;
  logic [1:0] eng_op;
  logic eng_done, eng_nak_rcvd, eng_bus_err, eng_arb_lost;
  logic bus_busy = 1'b0, scl_in = 1'b1, sda_in = 1'b1;

  i2c_msg_sequencer #(.MAX_MSGS(MAXM), .LEN_W(LENW), .TO_W(TOW), .RETRIES(RET),
    .GAP_CYCLES(GAP)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .num_msgs(num_msgs), .msg_addr(msg_addr),
    .msg_rd(msg_rd), .msg_nostart(msg_nostart), .msg_len(msg_len),
    .timeout_cycles(timeout_cycles), .wr_data(wr_data), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .done(done), .status(status), .arb_seen(arb_seen), .eng_go(eng_go), .eng_op(eng_op),
    .eng_start(eng_start), .eng_stop(eng_stop), .eng_nak(eng_nak), .eng_byte(eng_byte),
    .eng_reset(eng_reset), .eng_done(eng_done), .eng_nak_rcvd(eng_nak_rcvd),
    .eng_bus_err(eng_bus_err), .eng_arb_lost(eng_arb_lost), .eng_rx_byte(eng_rx_byte),
    .bus_busy(bus_busy), .scl_in(scl_in), .sda_in(sda_in)
  );

  int checks = 0, fails = 0;
  int cyc = 0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
    end
  endtask

  // ---------------- byte engine model ----------------
  logic [12:0] log_v [64];
  int          log_t [64];
  int          log_n = 0;
  bit nak_at[64], berr_at[64], arb_at[64], hang_at[64];
  int cnt = 0, cur = 0;

  always @(posedge clk) begin
    cyc++;
    eng_done <= 1'b0; eng_nak_rcvd <= 1'b0; eng_bus_err <= 1'b0; eng_arb_lost <= 1'b0;
    if (rst_n) begin
      if (eng_reset && log_n < 64) begin
        log_v[log_n] = {2'd3, 11'd0}; log_t[log_n] = cyc; log_n++;
      end
      if (eng_go && log_n < 64) begin
        log_v[log_n] = {eng_op, eng_start, eng_stop, eng_nak, eng_byte};
        log_t[log_n] = cyc; cur = log_n; log_n++;
        cnt = (eng_op == 2'd2 || !hang_at[cur]) ? 3 : 0;
      end else if (cnt > 0) begin
        cnt--;
        if (cnt == 0) begin
          eng_done <= 1'b1;
          eng_nak_rcvd <= nak_at[cur];
          eng_bus_err <= berr_at[cur];
          eng_arb_lost <= arb_at[cur];
          eng_rx_byte <= 8'hA0 + 8'(cur);
        end
      end
    end
  end

  // ---------------- write source / read sink ----------------
  logic [7:0] wq [16];
  int wp = 0, wn = 0;
  assign wr_data  = wq[wp[3:0]];
  assign wr_valid = (wp < wn);
  always @(posedge clk) if (wr_valid && wr_ready) wp <= wp + 1;

  logic [7:0] rq [16];
  int rn = 0;
  bit rd_stall = 1'b0;
  logic [1:0] rcnt = '0;
  always @(posedge clk) rcnt <= rcnt + 2'd1;
  assign rd_ready = rd_stall ? (rcnt == 2'd0) : 1'b1;
  always @(posedge clk) if (rd_valid && rd_ready && rn < 16) begin rq[rn] = rd_data; rn++; end

  // ---------------- helpers ----------------
  logic [12:0] ex_v [64];
  int ex_n = 0;
  logic [7:0] got_status;
  bit got_arb;

  function automatic logic [12:0] pk(input int op, input bit s, input bit p, input bit n,
                                     input logic [7:0] b);
    return {2'(op), s, p, n, b};
  endfunction

  task automatic ex(input int op, input bit s, input bit p, input bit n, input logic [7:0] b);
    ex_v[ex_n] = pk(op, s, p, n, b); ex_n++;
  endtask

  task automatic prep();
    @(negedge clk);
    log_n = 0; ex_n = 0; wp = 0; wn = 0; rn = 0; rd_stall = 1'b0; cnt = 0;
    for (int i = 0; i < 64; i++) begin
      nak_at[i] = 0; berr_at[i] = 0; arb_at[i] = 0; hang_at[i] = 0;
    end
    msg_rd = '0; msg_nostart = '0;
  endtask

  task automatic set_msg(input int i, input logic [6:0] a, input bit rd, input bit ns,
                         input int len);
    msg_addr[7*i +: 7] = a;
    msg_rd[i] = rd;
    msg_nostart[i] = ns;
    msg_len[LENW*i +: LENW] = LENW'(len);
  endtask

  task automatic push_wr(input logic [7:0] b);
    wq[wn[3:0]] = b; wn++;
  endtask

  task automatic run(input int n, input string req);
    num_msgs = CNTW'(n);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int k = 0; k < 5000; k++) begin
      if (done) begin
        got_status = status; got_arb = arb_seen;
        @(negedge clk);
        chk(!done, "R11 done width", int'(done), 0);
        return;
      end
      @(negedge clk);
    end
    chk(1'b0, {req, " watchdog: no done"}, 0, 1);
  endtask

  task automatic cmp_log(input string req);
    chk(log_n == ex_n, {req, " command count"}, log_n, ex_n);
    for (int i = 0; i < ex_n && i < log_n; i++)
      chk(log_v[i] == ex_v[i], {req, " command"}, int'(log_v[i]), int'(ex_v[i]));
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    chk(!done && !eng_go && !wr_ready && !rd_valid && !eng_reset, "R11 reset outputs",
        int'({done, eng_go, wr_ready, rd_valid}), 0);
  endtask

  task automatic t_write();  // R1 R3 R9 R11 R12
    prep();
    set_msg(0, 7'h50, 0, 0, 2); push_wr(8'h11); push_wr(8'h22);
    ex(0,1,0,0,8'hA0); ex(0,0,0,0,8'h11); ex(0,0,1,0,8'h22);
    run(1, "R3");
    cmp_log("R1/R3/R12 write");
    chk(got_status == 8'd1, "R11 ok status", got_status, 1);
    chk(!got_arb, "R9 arb clear", got_arb, 0);
  endtask

  task automatic t_read();  // R4 R13
    prep();
    rd_stall = 1'b1;
    set_msg(0, 7'h23, 1, 0, 3);
    ex(0,1,0,0,8'h47); ex(1,0,0,0,0); ex(1,0,0,0,0); ex(1,0,1,1,0);
    run(1, "R4");
    cmp_log("R4 read");
    chk(rn == 3, "R13 byte count", rn, 3);
    for (int i = 0; i < 3; i++)
      chk(rq[i] == 8'hA1 + 8'(i), "R13 read data", rq[i], 8'hA1 + i);
  endtask

  task automatic t_combined();  // R5
    prep();
    set_msg(0, 7'h50, 0, 0, 1); set_msg(1, 7'h50, 1, 0, 2); push_wr(8'h05);
    ex(0,1,0,0,8'hA0); ex(0,0,0,0,8'h05); ex(0,1,0,0,8'hA1); ex(1,0,0,0,0); ex(1,0,1,1,0);
    run(2, "R5");
    cmp_log("R5 repeated start");
    chk(got_status == 8'd2, "R11 two messages", got_status, 2);
  endtask

  task automatic t_nostart();  // R5
    prep();
    set_msg(0, 7'h10, 0, 0, 1); set_msg(1, 7'h33, 1, 1, 1);
    push_wr(8'hAA); push_wr(8'hBB);
    ex(0,1,0,0,8'h20); ex(0,0,0,0,8'hAA); ex(0,0,1,0,8'hBB);
    run(2, "R5");
    cmp_log("R5 no-restart continue");
    chk(got_status == 8'd2, "R5 status", got_status, 2);
  endtask

  task automatic t_retry();  // R6 R7
    prep();
    set_msg(0, 7'h50, 0, 0, 1); push_wr(8'h77);
    nak_at[0] = 1; nak_at[2] = 1;
    for (int i = 0; i < 2; i++) begin ex(0,1,0,0,8'hA0); ex(2,0,1,0,0); end
    ex(0,1,0,0,8'hA0); ex(0,0,1,0,8'h77);
    run(1, "R7");
    cmp_log("R6/R7 retry sequence");
    chk(got_status == 8'd1, "R7 recovered status", got_status, 1);
    chk(log_t[2] - log_t[1] > GAP, "R7 gap length", log_t[2] - log_t[1], GAP);
  endtask

  task automatic t_exhaust();  // R7
    prep();
    set_msg(0, 7'h50, 1, 0, 1);
    for (int i = 0; i <= RET; i++) begin nak_at[2*i] = 1; ex(0,1,0,0,8'hA1); ex(2,0,1,0,0); end
    run(1, "R7");
    cmp_log("R7 exhausted");
    chk(got_status == 8'h81, "R7 exhausted status", got_status, 8'h81);
  endtask

  task automatic t_late_nak();  // R6
    prep();
    set_msg(0, 7'h50, 0, 0, 2); push_wr(8'h01); push_wr(8'h02);
    nak_at[1] = 1;
    ex(0,1,0,0,8'hA0); ex(0,0,0,0,8'h01); ex(2,0,1,0,0);
    run(1, "R6");
    cmp_log("R6 data nak");
    chk(got_status == 8'h82, "R6 data nak status", got_status, 8'h82);
    prep();
    set_msg(0, 7'h50, 0, 0, 1); set_msg(1, 7'h50, 1, 0, 2); push_wr(8'h05);
    nak_at[2] = 1;
    ex(0,1,0,0,8'hA0); ex(0,0,0,0,8'h05); ex(0,1,0,0,8'hA1); ex(2,0,1,0,0);
    run(2, "R6");
    cmp_log("R6 second address nak");
    chk(got_status == 8'h82, "R6 second address status", got_status, 8'h82);
  endtask

  task automatic t_bus_err();  // R6
    prep();
    set_msg(0, 7'h50, 0, 0, 2); push_wr(8'h01); push_wr(8'h02);
    berr_at[1] = 1;
    ex(0,1,0,0,8'hA0); ex(0,0,0,0,8'h01); ex(2,0,1,0,0);
    run(1, "R6");
    cmp_log("R6 bus error");
    chk(got_status == 8'h83, "R6 bus error status", got_status, 8'h83);
  endtask

  task automatic t_probe();  // R8
    prep();
    set_msg(0, 7'h3C, 0, 0, 0);
    ex(0,1,1,0,8'h78); ex(3,0,0,0,0);
    run(1, "R8");
    cmp_log("R8 probe and reset");
    chk(got_status == 8'd1, "R8 status", got_status, 1);
  endtask

  task automatic t_arb();  // R9
    prep();
    set_msg(0, 7'h50, 0, 0, 2); push_wr(8'h31); push_wr(8'h32);
    arb_at[1] = 1;
    ex(0,1,0,0,8'hA0); ex(0,0,0,0,8'h31); ex(0,0,1,0,8'h32);
    run(1, "R9");
    cmp_log("R9 arbitration ignored");
    chk(got_status == 8'd1, "R9 status", got_status, 1);
    chk(got_arb, "R9 arb_seen", got_arb, 1);
  endtask

  task automatic t_idle_gate();  // R2
    prep();
    set_msg(0, 7'h50, 0, 0, 1); push_wr(8'h44);
    bus_busy = 1'b1;
    num_msgs = CNTW'(1);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (20) @(negedge clk);
    chk(log_n == 0, "R2 busy bus holds off", log_n, 0);
    bus_busy = 1'b0; sda_in = 1'b0;
    repeat (10) @(negedge clk);
    chk(log_n == 0, "R2 low SDA holds off", log_n, 0);
    sda_in = 1'b1;
    for (int k = 0; k < 200 && !done; k++) @(negedge clk);
    chk(done && status == 8'd1, "R2 proceeds when idle", status, 1);
    ex(0,1,0,0,8'hA0); ex(0,0,1,0,8'h44);
    cmp_log("R2 sequence");
  endtask

  task automatic t_timeout();  // R10
    prep();
    timeout_cycles = TOW'(60);
    set_msg(0, 7'h50, 0, 0, 2); push_wr(8'h09); push_wr(8'h0A);
    hang_at[1] = 1;
    ex(0,1,0,0,8'hA0); ex(0,0,0,0,8'h09); ex(2,0,1,0,0);
    run(1, "R10");
    cmp_log("R10 timeout abort");
    chk(got_status == 8'h84, "R10 timeout status", got_status, 8'h84);
    timeout_cycles = TOW'(1000);
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write();
    t_read();
    t_combined();
    t_nostart();
    t_retry();
    t_exhaust();
    t_late_nak();
    t_bus_err();
    t_probe();
    t_arb();
    t_idle_gate();
    t_timeout();
    finish_up();
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    finish_up();
  end

endmodule